// File: doc/BRIEF.md
# Transfer Descriptor Ring Controller

This block lets software queue bus transfers for an SMBus host engine without waiting on each one. Software fills 16-byte descriptors in a small circular ring in system memory, then moves a head index forward in a control register. The controller follows with its own tail index. While the ring is running and the tail lags the head, it reads the descriptor at the tail from memory as four 32-bit words and hands the fields to the bus sequencer. When the sequencer finishes, the controller writes the result bytes back into the descriptor and steps the tail forward, wrapping at the ring size.

Completion and error events are kept as sticky status bits. Software clears them by writing ones, and they drive one interrupt line. A bus-rate field is passed on to the sequencer. The sequencer itself lies outside the block. Memory is reached through a plain request/acknowledge port.

The engine has six states:
- IDLE leaves for FETCH when the ring is started and the tail differs from the head.
- FETCH reads word 0 to word 3, advancing on each acknowledge, and goes to LAUNCH after the last one.
- LAUNCH pulses the sequencer start and moves to WAIT.
- WAIT stays until the sequencer reports done, then moves to WBACK.
- WBACK writes the result word and moves to STEP on acknowledge.
- STEP advances the tail, raises any events, and returns to IDLE.

Top module: `drc_ring_ctrl`

## Requirements
- R1: After reset:
  - every register reads zero;
  - the tail index is 0;
  - irq is low;
  - no memory request is made.
- R2: Register map, with unwritten bits reading 0.
  - Offset 0x00 holds the ring base address.
  - Offset 0x04 is control: bit 0 start, bit 4 error-interrupt enable, bits 23:16 head index.
  - Offset 0x0C holds the ring size, entries minus one, in bits 7:0.
  - Offset 0x10 holds the bus rate in bits 31:30, driven on bus_rate: 0 = 80 kHz, 1 = 100 kHz, 2 = 400 kHz, 3 = 1 MHz.
- R3: No descriptor is fetched while start is 0 or while the tail equals the head.
- R4: A fetch reads four words, in order k = 0..3, at base + 16*tail + 4*k, holding each request until it is acknowledged. Byte 0 is address/RW, byte 1 is write length or command, byte 2 is read length, byte 3 is control, byte 5 is retry, and bytes 8..15 are the data pointer. These fields appear on the seq_* outputs.
- R5: After the fourth word, seq_start is high for exactly one cycle, and the block then waits for seq_done.
- R6: Write-back is one write to base + 16*tail + 4, with strobe 1101 and data {tx count, rx count, retry, status}. Only the status byte (4), the rx-count byte (6) and the tx-count byte (7) change.
- R7: After write-back, the tail advances by one modulo (size + 1). It reads in bits 23:16 of status (offset 0x08).
- R8: Status bit 5 (completion) is set when the finished descriptor has control bit 6 set.
- R9: Status bit 4 (error) is set when the returned status byte has bit 0 (success) clear.
- R10: Writing a 1 to status bit 5 or bit 4 clears that bit. Writing a 0 leaves it unchanged.
- R11: irq = bit5 OR (bit4 AND error-interrupt enable).
- R12: Status bit 0 is high whenever the engine is outside IDLE. If start is cleared while a descriptor is in flight, that descriptor completes and no further descriptor is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wstrb | output | 4 | Memory byte-lane enables |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_addr_rw | output | 8 | Descriptor byte 0 |
| seq_wr_len | output | 8 | Descriptor byte 1 |
| seq_rd_len | output | 8 | Descriptor byte 2 |
| seq_ctrl | output | 8 | Descriptor byte 3 |
| seq_retry | output | 8 | Descriptor byte 5 |
| seq_dptr | output | 64 | Descriptor data pointer |
| bus_rate | output | 2 | Bus rate selection |
| seq_done | input | 1 | Sequencer completion |
| seq_status | input | 8 | Returned status byte |
| seq_rx_cnt | input | 8 | Returned received-byte count |
| seq_tx_cnt | input | 8 | Returned transmitted-byte count |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume the following about the inputs:
- memory acknowledges a request only while it is held;
- seq_done arrives only while the engine waits in WAIT;
- software moves the head only onto ring slots that hold valid descriptors.

The bench stays within these assumptions:
- its memory model answers one request at a time, acknowledging on the falling edge after it sees the request and dropping the acknowledge one cycle later;
- its sequencer model replies a fixed three cycles after each start pulse;
- every head value it writes points just past descriptors it has already placed in memory.

Each expected fetch, write-back and sequencer hand-off is queued in advance, so any unqueued memory traffic shows up as a failed check.

// File: rtl/drc_pkg.sv
package drc_pkg;
    localparam int IDX_W      = 8;
    localparam int REG_AW     = 5;
    localparam int DESC_BYTES = 16;
    localparam int DESC_WORDS = DESC_BYTES / 4;
    localparam int WB_WORD    = 1;
    localparam int WSEL_W     = $clog2(DESC_WORDS);

    localparam logic [REG_AW-1:0] OFS_BASE  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_STAT  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_SIZE  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_SPEED = 5'h10;

    localparam int B_START = 0;
    localparam int B_EIE   = 4;
    localparam int B_BUSY  = 0;
    localparam int B_EIS   = 4;
    localparam int B_CIS   = 5;
    localparam int B_IDX   = 16;
    localparam int B_RATE  = 30;
    localparam int B_DINT  = 6;
    localparam int B_SUCC  = 0;

    localparam logic [3:0] WB_STRB = 4'b1101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LAUNCH,
        ST_WAIT,
        ST_WBACK,
        ST_STEP
    } eng_state_t;
endpackage

// File: rtl/drc_regs.sv
module drc_regs
    import drc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [IDX_W-1:0]    tail,
    input  logic                busy,
    input  logic                set_cis,
    input  logic                set_eis,
    output logic [ADDR_W-1:0]   base,
    output logic                start,
    output logic                eie,
    output logic [IDX_W-1:0]    head,
    output logic [IDX_W-1:0]    size,
    output logic [1:0]          rate,
    output logic                cis,
    output logic                eis,
    output logic                irq
);
    logic stat_wr;

    assign stat_wr = wr_en && (addr == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base  <= '0;
            start <= 1'b0;
            eie   <= 1'b0;
            head  <= '0;
            size  <= '0;
            rate  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_BASE: base <= wdata[ADDR_W-1:0];
                OFS_CTRL: begin
                    start <= wdata[B_START];
                    eie   <= wdata[B_EIE];
                    head  <= wdata[B_IDX +: IDX_W];
                end
                OFS_SIZE:  size <= wdata[IDX_W-1:0];
                OFS_SPEED: rate <= wdata[B_RATE +: 2];
                default: ;
            endcase
        end
    end

    // sticky events: a new event in the same cycle outweighs a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cis <= 1'b0;
            eis <= 1'b0;
        end else begin
            cis <= set_cis | (cis & ~(stat_wr & wdata[B_CIS]));
            eis <= set_eis | (eis & ~(stat_wr & wdata[B_EIS]));
        end
    end

    assign irq = cis | (eis & eie);

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_BASE: rdata[ADDR_W-1:0] = base;
            OFS_CTRL: begin
                rdata[B_START]        = start;
                rdata[B_EIE]          = eie;
                rdata[B_IDX +: IDX_W] = head;
            end
            OFS_STAT: begin
                rdata[B_BUSY]         = busy;
                rdata[B_EIS]          = eis;
                rdata[B_CIS]          = cis;
                rdata[B_IDX +: IDX_W] = tail;
            end
            OFS_SIZE:  rdata[IDX_W-1:0] = size;
            OFS_SPEED: rdata[B_RATE +: 2] = rate;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/drc_tail.sv
module drc_tail
    import drc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W-1:0] size,
    output logic [IDX_W-1:0] tail
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (adv) begin
            if (tail >= size) tail <= '0;
            else              tail <= tail + 1'b1;
        end
    end
endmodule

// File: rtl/drc_engine.sv
module drc_engine
    import drc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  head,
    input  logic [IDX_W-1:0]  tail,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              seq_start,
    output logic [7:0]        d_addr_rw,
    output logic [7:0]        d_wr_len,
    output logic [7:0]        d_rd_len,
    output logic [7:0]        d_ctrl,
    output logic [7:0]        d_retry,
    output logic [63:0]       d_dptr,
    input  logic              seq_done,
    input  logic [7:0]        seq_status,
    input  logic [7:0]        seq_rx_cnt,
    input  logic [7:0]        seq_tx_cnt,
    output logic              tail_adv,
    output logic              set_cis,
    output logic              set_eis,
    output logic              busy
);
    localparam int SLOT_SH = $clog2(DESC_BYTES);

    eng_state_t                  state;
    logic [WSEL_W-1:0]           word_q;
    logic [DESC_WORDS*32-1:0]    dw_flat;
    logic [7:0]                  st_q, rx_q, tx_q;
    logic [ADDR_W-1:0]           slot_addr;

    assign slot_addr = base + (ADDR_W'(tail) << SLOT_SH);

    // one capture register per descriptor word
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_cap
        logic [31:0] cap_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cap_q <= '0;
            else if (state == ST_FETCH && mem_ack && word_q == WSEL_W'(g))
                cap_q <= mem_rdata;
        end
        assign dw_flat[g*32 +: 32] = cap_q;
    end

    assign d_addr_rw = dw_flat[7:0];
    assign d_wr_len  = dw_flat[15:8];
    assign d_rd_len  = dw_flat[23:16];
    assign d_ctrl    = dw_flat[31:24];
    assign d_retry   = dw_flat[47:40];
    assign d_dptr    = dw_flat[127:64];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            word_q <= '0;
            st_q   <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    word_q <= '0;
                    if (start && tail != head) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (word_q == WSEL_W'(DESC_WORDS - 1)) state <= ST_LAUNCH;
                        else word_q <= word_q + 1'b1;
                    end
                end
                ST_LAUNCH: state <= ST_WAIT;
                ST_WAIT: begin
                    if (seq_done) begin
                        st_q  <= seq_status;
                        rx_q  <= seq_rx_cnt;
                        tx_q  <= seq_tx_cnt;
                        state <= ST_WBACK;
                    end
                end
                ST_WBACK: if (mem_ack) state <= ST_STEP;
                ST_STEP:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wstrb = '0;
        seq_start = 1'b0;
        tail_adv  = 1'b0;
        set_cis   = 1'b0;
        set_eis   = 1'b0;
        busy      = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: ;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr + (ADDR_W'(word_q) << 2);
            end
            ST_LAUNCH: seq_start = 1'b1;
            ST_WAIT: ;
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot_addr + ADDR_W'(WB_WORD * 4);
                mem_wdata = {tx_q, rx_q, d_retry, st_q};
                mem_wstrb = WB_STRB;
            end
            ST_STEP: begin
                tail_adv = 1'b1;
                set_cis  = d_ctrl[B_DINT];
                set_eis  = ~st_q[B_SUCC];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/drc_ring_ctrl.sv
module drc_ring_ctrl
    import drc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              seq_start,
    output logic [7:0]        seq_addr_rw,
    output logic [7:0]        seq_wr_len,
    output logic [7:0]        seq_rd_len,
    output logic [7:0]        seq_ctrl,
    output logic [7:0]        seq_retry,
    output logic [63:0]       seq_dptr,
    output logic [1:0]        bus_rate,
    input  logic              seq_done,
    input  logic [7:0]        seq_status,
    input  logic [7:0]        seq_rx_cnt,
    input  logic [7:0]        seq_tx_cnt,
    output logic              irq
);
    logic [ADDR_W-1:0] base_q;
    logic              start_q, eie_q, cis_q, eis_q;
    logic [IDX_W-1:0]  head_idx, tail_idx, size_q;
    logic              tail_adv, set_cis, set_eis, busy;

    drc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .tail   (tail_idx),
        .busy   (busy),
        .set_cis(set_cis),
        .set_eis(set_eis),
        .base   (base_q),
        .start  (start_q),
        .eie    (eie_q),
        .head   (head_idx),
        .size   (size_q),
        .rate   (bus_rate),
        .cis    (cis_q),
        .eis    (eis_q),
        .irq    (irq)
    );

    drc_tail u_tail (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (tail_adv),
        .size (size_q),
        .tail (tail_idx)
    );

    drc_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_q),
        .head      (head_idx),
        .tail      (tail_idx),
        .base      (base_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_wstrb (mem_wstrb),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .seq_start (seq_start),
        .d_addr_rw (seq_addr_rw),
        .d_wr_len  (seq_wr_len),
        .d_rd_len  (seq_rd_len),
        .d_ctrl    (seq_ctrl),
        .d_retry   (seq_retry),
        .d_dptr    (seq_dptr),
        .seq_done  (seq_done),
        .seq_status(seq_status),
        .seq_rx_cnt(seq_rx_cnt),
        .seq_tx_cnt(seq_tx_cnt),
        .tail_adv  (tail_adv),
        .set_cis   (set_cis),
        .set_eis   (set_eis),
        .busy      (busy)
    );
endmodule

// File: rtl/drc_ring_ctrl_chk.sv
module drc_ring_ctrl_chk
    import drc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_wstrb,
    input logic              seq_start,
    input logic              irq,
    input logic              busy,
    input logic [IDX_W-1:0]  tail_idx,
    input logic              tail_adv,
    input logic              cis_q,
    input logic              eis_q
);
    // R4: a request stays up, at the same address, until it is acknowledged
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5: the sequencer start is a single-cycle pulse
    a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    // R6: every write uses the write-back lane mask
    a_r6_wb_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wstrb == WB_STRB));

    // R7: the tail only moves on an advance from the engine
    a_r7_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_idx != $past(tail_idx)) |-> $past(tail_adv));

    // R11: no interrupt without a pending event
    a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cis_q && !eis_q) |-> !irq);

    // R12: the busy flag covers every sequencer launch
    a_r12_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> busy);
endmodule

bind drc_ring_ctrl drc_ring_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wstrb(mem_wstrb),
    .seq_start(seq_start),
    .irq      (irq),
    .busy     (busy),
    .tail_idx (tail_idx),
    .tail_adv (tail_adv),
    .cis_q    (cis_q),
    .eis_q    (eis_q)
);

// File: tb/tb_drc_ring_ctrl.sv
module tb_drc_ring_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RING_BASE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        seq_start;
    logic [7:0]  seq_addr_rw, seq_wr_len, seq_rd_len, seq_ctrl, seq_retry;
    logic [63:0] seq_dptr;
    logic [1:0]  bus_rate;
    logic        seq_done = 1'b0;
    logic [7:0]  seq_status = '0, seq_rx_cnt = '0, seq_tx_cnt = '0;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    drc_ring_ctrl dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } mx_t;
    typedef struct { logic [39:0] flds; logic [63:0] dptr;
                     logic [7:0] st; logic [7:0] rx; logic [7:0] tx; } sx_t;
    mx_t mq[$];
    sx_t sq[$];
    logic [31:0] mem [64];

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
        end else if (mem_req && !mem_ack) begin
            if (mq.size() == 0) begin
                chk(0, "R3", "unexpected memory request", {mem_we, mem_addr}, 0);
            end else begin
                mx_t e;
                e = mq.pop_front();
                chk({mem_we, mem_addr} == {e.we, e.addr}, e.we ? "R6" : "R4",
                    "request kind/address", {mem_we, mem_addr}, {e.we, e.addr});
                if (e.we)
                    chk(mem_wdata == e.data && mem_wstrb == 4'b1101, "R6",
                        "write-back data/strobe", {mem_wstrb, mem_wdata}, {4'b1101, e.data});
            end
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[mem_addr[7:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata = mem[mem_addr[7:2]];
            end
            mem_ack = 1'b1;
        end else begin
            mem_ack = 1'b0;
        end
    end

    // sequencer model and monitor
    int  sq_cnt = 0;
    bit  prev_start = 0;
    sx_t cur;
    always @(negedge clk) begin
        seq_done = 1'b0;
        if (rst_n && seq_start) begin
            chk(!prev_start, "R5", "start pulse width", 1, 0);
            if (sq.size() == 0) begin
                chk(0, "R5", "unexpected sequencer start", 1, 0);
            end else begin
                cur = sq.pop_front();
                chk({seq_addr_rw, seq_wr_len, seq_rd_len, seq_ctrl, seq_retry} == cur.flds,
                    "R4", "descriptor fields", {24'h0, seq_addr_rw, seq_wr_len, seq_rd_len, seq_ctrl, seq_retry},
                    {24'h0, cur.flds});
                chk(seq_dptr == cur.dptr, "R4", "data pointer", seq_dptr, cur.dptr);
                sq_cnt = 3;
            end
        end else if (sq_cnt > 0) begin
            sq_cnt--;
            if (sq_cnt == 0) begin
                seq_done   = 1'b1;
                seq_status = cur.st;
                seq_rx_cnt = cur.rx;
                seq_tx_cnt = cur.tx;
            end
        end
        prev_start = seq_start;
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // driver: place a descriptor and queue what it must produce
    task automatic post(input int i, input logic [7:0] arw, input logic [7:0] wl,
                        input logic [7:0] rl, input logic [7:0] ct, input logic [7:0] rt,
                        input logic [63:0] dp, input logic [7:0] st, input logic [7:0] rx,
                        input logic [7:0] tx, input bit expect_it);
        logic [31:0] slot;
        slot = RING_BASE + 32'(i * 16);
        mem[4*i+0] = {ct, rl, wl, arw};
        mem[4*i+1] = {8'hEE, 8'hEE, rt, 8'hEE};
        mem[4*i+2] = dp[31:0];
        mem[4*i+3] = dp[63:32];
        if (expect_it) begin
            for (int k = 0; k < 4; k++) mq.push_back('{0, slot + 32'(4*k), 32'h0});
            sq.push_back('{{arw, wl, rl, ct, rt}, dp, st, rx, tx});
            mq.push_back('{1, slot + 32'd4, {tx, rx, rt, st}});
        end
    endtask

    task automatic wait_idle(input string rq);
        logic [31:0] s;
        int n;
        n = 0;
        do begin
            @(negedge clk);
            rd(5'h08, s);
            n++;
        end while ((mq.size() != 0 || sq.size() != 0 || s[0]) && n < 3000);
        chk(mq.size() == 0 && sq.size() == 0, rq, "all queued work done",
            mq.size() + sq.size(), 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete (R1..R12 incomplete) actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); chk(v == 0, "R1", "base after reset", v, 0);
        rd(5'h04, v); chk(v == 0, "R1", "control after reset", v, 0);
        rd(5'h08, v); chk(v == 0, "R1", "status after reset", v, 0);
        rd(5'h0C, v); chk(v == 0, "R1", "size after reset", v, 0);
        rd(5'h10, v); chk(v == 0, "R1", "speed after reset", v, 0);
        chk(!irq && !mem_req, "R1", "irq/mem_req after reset", {irq, mem_req}, 0);

        // R2 register fields
        wr(5'h04, 32'hFFFF_FFFE);
        rd(5'h04, v); chk(v == 32'h00FF_0010, "R2", "control field mask", v, 32'h00FF_0010);
        wr(5'h0C, 32'h0000_01FF);
        rd(5'h0C, v); chk(v == 32'h0000_00FF, "R2", "size field mask", v, 32'hFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, v); chk(v == 32'hC000_0000 && bus_rate == 2'd3, "R2", "speed 1 MHz code",
                          {bus_rate, v}, {2'd3, 32'hC000_0000});
        wr(5'h10, 32'h4000_0000);
        chk(bus_rate == 2'd1, "R2", "speed 100 kHz code", bus_rate, 1);
        wr(5'h00, RING_BASE);
        rd(5'h00, v); chk(v == RING_BASE, "R2", "base readback", v, RING_BASE);
        wr(5'h0C, 32'd3);
        wr(5'h04, 32'h0000_0000);

        // R3: head ahead but not started, then started with head == tail
        post(0, 8'hA1, 8'h02, 8'h00, 8'h40, 8'h03, 64'h1111_2222_3333_4444, 8'h01, 8'h00, 8'h02, 0);
        wr(5'h04, 32'h0002_0000);
        repeat (30) @(negedge clk);
        rd(5'h08, v); chk(v == 0, "R3", "no progress while stopped", v, 0);
        wr(5'h04, 32'h0000_0001);
        repeat (30) @(negedge clk);
        rd(5'h08, v); chk(v == 0, "R3", "no progress when tail equals head", v, 0);

        // R4..R9: two descriptors, one with interrupt request, one failing
        post(0, 8'hA1, 8'h02, 8'h00, 8'h40, 8'h03, 64'h1111_2222_3333_4444, 8'h01, 8'h00, 8'h02, 1);
        post(1, 8'h50, 8'h07, 8'h02, 8'h08, 8'h05, 64'hDEAD_BEEF_0000_0200, 8'h08, 8'h01, 8'h03, 1);
        wr(5'h04, 32'h0002_0001);
        wait_idle("R4");
        rd(5'h08, v); chk(v == 32'h0002_0030, "R7", "tail 2, completion and error set", v, 32'h0002_0030);
        chk(mem[1] == 32'h0200_0301, "R6", "write-back bytes slot 0", mem[1], 32'h0200_0301);
        chk(mem[5] == 32'h0301_0508, "R6", "write-back bytes slot 1", mem[5], 32'h0301_0508);
        chk(irq == 1'b1, "R8", "irq from completion", irq, 1);

        // R10, R11 write-one-to-clear and masking
        wr(5'h08, 32'h0000_0020);
        rd(5'h08, v); chk(v == 32'h0002_0010, "R10", "completion cleared, error kept", v, 32'h0002_0010);
        chk(irq == 1'b0, "R11", "masked error gives no irq", irq, 0);
        wr(5'h04, 32'h0002_0011);
        chk(irq == 1'b1, "R11", "enabled error gives irq", irq, 1);
        wr(5'h08, 32'h0000_0000);
        rd(5'h08, v); chk(v == 32'h0002_0010, "R10", "writing zero keeps error", v, 32'h0002_0010);
        wr(5'h08, 32'h0000_0010);
        rd(5'h08, v); chk(v == 32'h0002_0000 && !irq, "R10", "error cleared", {irq, v}, 32'h0002_0000);

        // R7 wrap: slots 2, 3, 0 with head moved to 1
        post(2, 8'h11, 8'h01, 8'h01, 8'h00, 8'h00, 64'h0000_0000_0000_0300, 8'h01, 8'h01, 8'h01, 1);
        post(3, 8'h22, 8'h03, 8'h00, 8'h40, 8'h01, 64'h0000_0001_0000_0400, 8'h01, 8'h00, 8'h03, 1);
        post(0, 8'h33, 8'h00, 8'h20, 8'h04, 8'h02, 64'h0000_0000_0000_0500, 8'h04, 8'h05, 8'h01, 1);
        wr(5'h04, 32'h0001_0011);
        wait_idle("R7");
        rd(5'h08, v); chk(v == 32'h0001_0030, "R7", "tail wrapped to 1 with events", v, 32'h0001_0030);
        chk(irq == 1'b1, "R9", "irq after failing descriptor", irq, 1);
        wr(5'h08, 32'h0000_0030);
        chk(irq == 1'b0, "R10", "both events cleared", irq, 0);

        // R12: stop while a descriptor is in flight
        post(1, 8'h44, 8'h01, 8'h00, 8'h00, 8'h00, 64'h0000_0000_0000_0600, 8'h01, 8'h00, 8'h01, 1);
        post(2, 8'h55, 8'h01, 8'h00, 8'h00, 8'h00, 64'h0000_0000_0000_0700, 8'h01, 8'h00, 8'h01, 0);
        wr(5'h04, 32'h0003_0011);
        do @(negedge clk); while (!seq_start);
        rd(5'h08, v); chk(v[0] == 1'b1, "R12", "busy while descriptor in flight", v[0], 1);
        wr(5'h04, 32'h0003_0010);
        wait_idle("R12");
        repeat (30) @(negedge clk);
        rd(5'h08, v); chk(v == 32'h0002_0000, "R12", "stopped after one, idle", v, 32'h0002_0000);
        chk(!irq, "R12", "no event from stopped run", irq, 0);

        summary();
    end
endmodule